// File: doc/BRIEF.md
# Programmable Square-Wave Frequency Generator

This block drives a continuous square wave with equal high and low times. Its period comes from two numbers written together: a 16-bit count and a power-of-two prescaler select. A single-cycle write strobe delivers both. A build-time option inverts the output polarity.

When a new setting arrives while the wave is running, it is held until the current full period has ended, so the waveform never shows a torn cycle. There are two exceptions. A write of zero stops the wave at once. A nonzero write to a stopped generator starts it after a fixed two-cycle latency. Typical loads are a tone transducer or a frequency-to-voltage stage.

Top module: `sqwave_gen`

## Requirements
- R1: After reset the generator is stopped with a count of zero, and `wave_out` sits at its idle level.
- R2: While running, every high phase and every low phase lasts exactly (count + n) × 2^(sel+1) clock cycles, so one period is (count + n) × 4 × 2^sel cycles with a 50% duty cycle.
- R3: n is 1 when sel is 0 and 0 for any other sel. For example, count 1 with sel 0 gives the same 4-cycle half period as count 1 with sel 1.
- R4: A nonzero write to a stopped generator starts it. Call the clock edge that samples the strobe the write edge. After the write edge the output is still idle. After the next edge the output is in its active phase, and a fresh waveform always begins active.
- R5: A zero write stops the generator on the write edge, whatever phase it is in, and discards any pending setting.
- R6: A nonzero write while running does not alter the waveform in progress. The new setting takes effect at the end of the current period, which is the edge where the active phase begins again.
- R7: If several nonzero writes arrive within one period, only the last is applied at the period boundary.
- R8: With INVERT = 0 the idle level is 0 and the active phase is high. With INVERT = 1 the output is the exact complement at all times, so the idle level is 1.
- R9: The prescaler select is SEL_W bits wide. The default of 3 covers sel 0..7, and SEL_W = 4 covers 0..15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_value | input | VAL_W | Period count; zero stops the output |
| wr_sel | input | SEL_W | Prescaler select (power-of-two exponent) |
| wave_out | output | 1 | Square-wave output |

## Verification
The prescaler and half-period counters are hidden state. Any fault in them shows up as a wrong phase length on `wave_out`, visible within the first half period after a start. A fault in the pending-setting logic shows up one period later: the new length appears a period too early, too late, or with a stale value. Each of those periods is therefore measured cycle by cycle. A broken stop or start path is visible one or two edges after the strobe.

// File: rtl/sqwave_gen.sv
module sqwave_gen #(
  parameter int VAL_W  = 16,
  parameter int SEL_W  = 3,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_value,
  input  logic [SEL_W-1:0] wr_sel,
  output logic             wave_out
);
  localparam int PRE_W = (1 << SEL_W) + 1;
  localparam int CNT_W = VAL_W + 1;

  logic             run, arm, lvl, pend_v;
  logic [VAL_W-1:0] cur_val, pend_val;
  logic [SEL_W-1:0] cur_sel, pend_sel;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;

  wire [PRE_W-1:0] pre_max  = (PRE_W'(2) << cur_sel) - PRE_W'(1);
  wire [CNT_W-1:0] units_m1 = CNT_W'(cur_val) - CNT_W'(cur_sel != '0);
  wire             pre_end  = (pre == pre_max);
  wire             wr_zero  = wr_en && (wr_value == '0);
  wire             wr_go    = wr_en && (wr_value != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      arm      <= 1'b0;
      lvl      <= 1'b0;
      pend_v   <= 1'b0;
      cur_val  <= '0;
      cur_sel  <= '0;
      pend_val <= '0;
      pend_sel <= '0;
      pre      <= '0;
      cnt      <= '0;
    end else if (wr_zero) begin
      run    <= 1'b0;
      arm    <= 1'b0;
      lvl    <= 1'b0;
      pend_v <= 1'b0;
    end else begin
      if (run) begin
        if (pre_end) begin
          pre <= '0;
          if (cnt == units_m1) begin
            cnt <= '0;
            lvl <= !lvl;
            if (!lvl && pend_v) begin
              cur_val <= pend_val;
              cur_sel <= pend_sel;
              pend_v  <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end else if (arm && !wr_go) begin
        arm <= 1'b0;
        run <= 1'b1;
        lvl <= 1'b1;
        pre <= '0;
        cnt <= '0;
      end
      if (wr_go && run) begin
        pend_val <= wr_value;
        pend_sel <= wr_sel;
        pend_v   <= 1'b1;
      end else if (wr_go) begin
        cur_val <= wr_value;
        cur_sel <= wr_sel;
        arm     <= 1'b1;
      end
    end
  end

  assign wave_out = lvl ^ INVERT;
endmodule

module sqwave_gen_chk #(
  parameter int VAL_W  = 16,
  parameter bit INVERT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [VAL_W-1:0] wr_value,
  input logic             wave_out,
  input logic             run,
  input logic             arm,
  input logic             lvl,
  input logic [VAL_W-1:0] cur_val
);
  // R5
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_value == '0) |=> (wave_out == INVERT && !run && !arm));

  // R4
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !wr_en) |=> (run && wave_out != INVERT));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !arm) |-> (wave_out == INVERT));

  // R6
  reload_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(cur_val)) |-> $rose(lvl));

  // R4
  state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run, arm}));
endmodule

bind sqwave_gen sqwave_gen_chk #(.VAL_W(VAL_W), .INVERT(INVERT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
  .wave_out(wave_out), .run(run), .arm(arm), .lvl(lvl), .cur_val(cur_val)
);

// File: tb/test_sqwave_gen.sv
module test_sqwave_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_value = '0;
  logic [2:0]  wr_sel = '0;
  logic        wave_out, wave_inv;
  int checks = 0, errors = 0, inv_mism = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqwave_gen #(.VAL_W(16), .SEL_W(3), .INVERT(1'b0)) i_sqwave_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
    .wr_sel(wr_sel), .wave_out(wave_out));

  sqwave_gen #(.VAL_W(16), .SEL_W(3), .INVERT(1'b1)) i_sqwave_gen_inv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
    .wr_sel(wr_sel), .wave_out(wave_inv));

  always @(negedge clk) if (rst_n && wave_inv !== ~wave_out) inv_mism++;

  function automatic int half(input int v, input int s);
    return (v + (s == 0 ? 1 : 0)) << (s + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic start_wave(input int v, input int s);
    wr_en = 1'b1; wr_value = 16'(v); wr_sel = 3'(s);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 idle after write edge", int'(wave_out), 0);
    @(negedge clk);
    chk("R4 active after second edge", int'(wave_out), 1);
  endtask

  task automatic stop_wave();
    wr_en = 1'b1; wr_value = '0; wr_sel = '0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 stopped on write edge", int'(wave_out), 0);
    repeat (3) @(negedge clk);
    chk("R5 stays idle", int'(wave_out), 0);
  endtask

  task automatic run_phase(input logic lv, input int inj, input int v, input int s, output int n);
    n = 0;
    while (wave_out == lv && n < 100000) begin
      n++;
      if (n == inj) begin wr_en = 1'b1; wr_value = 16'(v); wr_sel = 3'(s); end
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic expect_periods(input string tag, input int h, input int reps);
    int n;
    for (int i = 0; i < reps; i++) begin
      run_phase(1'b1, 0, 0, 0, n); chk({tag, " high"}, n, h);
      run_phase(1'b0, 0, 0, 0, n); chk({tag, " low"}, n, h);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, v1, s1, v2, s2, v3, s3, h1, inj;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 idle in reset", int'(wave_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", int'(wave_out), 0);
    chk("R8 inverted idle", int'(wave_inv), 1);

    // R3 directed: sel 0 adds one count
    start_wave(1, 0); expect_periods("R3 v1 s0", 4, 2); stop_wave();
    start_wave(1, 1); expect_periods("R3 v1 s1", 4, 2); stop_wave();
    start_wave(3, 0); expect_periods("R3 v3 s0", 8, 1); stop_wave();
    // R9 widest default select
    start_wave(1, 7); expect_periods("R9 v1 s7", 256, 1); stop_wave();

    // R2 random lengths, R5 stop mid-phase
    for (int t = 0; t < 12; t++) begin
      v1 = $urandom_range(1, 30); s1 = $urandom_range(0, 3);
      start_wave(v1, s1);
      expect_periods("R2 random", half(v1, s1), 1);
      repeat ($urandom_range(0, half(v1, s1) - 2)) @(negedge clk);
      stop_wave();
    end

    // R6 deferred reload, injected in high or low phase
    for (int t = 0; t < 8; t++) begin
      v1 = $urandom_range(1, 20); s1 = $urandom_range(0, 3);
      v2 = $urandom_range(1, 20); s2 = $urandom_range(0, 3);
      h1 = half(v1, s1); inj = $urandom_range(1, h1 - 1);
      start_wave(v1, s1);
      run_phase(1'b1, (t % 2 == 0) ? inj : 0, v2, s2, n); chk("R6 old high", n, h1);
      run_phase(1'b0, (t % 2 == 1) ? inj : 0, v2, s2, n); chk("R6 old low", n, h1);
      expect_periods("R6 new", half(v2, s2), 1);
      stop_wave();
    end

    // R7 last write wins
    for (int t = 0; t < 4; t++) begin
      v1 = $urandom_range(1, 20); s1 = $urandom_range(0, 3);
      v2 = $urandom_range(1, 20); s2 = $urandom_range(0, 3);
      v3 = $urandom_range(1, 20); s3 = $urandom_range(0, 3);
      h1 = half(v1, s1);
      start_wave(v1, s1);
      run_phase(1'b1, 1, v2, s2, n); chk("R7 old high", n, h1);
      run_phase(1'b0, h1 - 1, v3, s3, n); chk("R7 old low", n, h1);
      expect_periods("R7 last value", half(v3, s3), 2);
      stop_wave();
    end

    // R5 zero write discards pending setting
    start_wave(5, 1);
    run_phase(1'b1, 2, 2, 0, n);
    repeat (2) @(negedge clk);
    stop_wave();
    start_wave(3, 2);
    expect_periods("R5 pending cleared", half(3, 2), 2);
    stop_wave();

    chk("R8 inverted complement mismatches", inv_mism, 0);
    chk("R8 inverted idle end", int'(wave_inv), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule